// File: doc/BRIEF.md
# Single-Channel DMA Transfer Sequencer

This block is one DMA channel. Software programs a source pointer, a destination pointer, a transfer count and a control word through a small register port. It then sets the start bit. The channel runs the programmed number of bus transfers. Each transfer is a read on the read master followed by a write of the same data on the write master. Each pointer either advances by the transfer width after every transfer or stays fixed. Either pointer can also wrap inside an aligned power-of-two window.

The control word selects the following:
- the transfer width;
- byte reversal inside a halfword or word before the write;
- gating of each read request by one of several transfer-request lines, so that a slow peripheral can pace the channel.

The channel reports busy while it runs, pulses a done output when it finishes, and latches read and write bus errors. An interrupt request is raised at completion unless it is silenced. Both bus sides use a request valid/ready handshake followed by a one-beat response carrying an error bit. Data for byte and halfword transfers travels in the low lanes of the data bus.

Top module: `dma_chan_seq`

## Requirements
- R1: Control bits [1:0] select the width: 0 = byte, 1 = halfword, 2 = word. An incrementing pointer advances by 1, 2 or 4 after each completed transfer. Read data arrives right-justified, and the write carries the same number of low bytes.
- R2: The count is in bus transfers. After start (control bit 31 written as 1 while idle), exactly the programmed number of read requests are issued. A count of zero issues none and still completes.
- R3: Control bit 2 enables read-pointer increment and bit 3 enables write-pointer increment, independently. A disabled pointer keeps its value for the whole sequence.
- R4: Control bits [7:4] give a ring size N. When N is non-zero, only the low N bits of the selected pointer change on increment, so it wraps inside its 2^N-byte window. Control bit 8 selects the pointer: 1 selects the write pointer, 0 selects the read pointer. N = 0 gives a plain increment.
- R5: When control bit 9 is set, the byte order inside each halfword or word is reversed before the write. Byte transfers are unaffected.
- R6: When control bit 10 is set, a read is requested only while the request line chosen by control bits [13:11] is high.
- R7: The busy output, and control bit 24 on read, go high at start and low when the sequence ends or aborts.
- R8: A read error response sets control bit 16 and a write error response sets bit 17. Either one aborts the sequence without a done pulse, and the pointers are not advanced. Writing 1 to a flag clears it. Bit 18 reads as the OR of the two flags.
- R9: Reading the count register returns the transfers left in the current sequence. Writing it sets only the reload value used at the next start.
- R10: Reading a pointer register (read pointer at offset 0, write pointer at offset 1) returns the address of the next transfer. A write to either takes effect from the next transfer, including while the channel is busy.
- R11: At completion, done is high for exactly one cycle, with busy already low. The irq output, also readable as control bit 19, is set at completion unless control bit 14 is set. Writing 1 to bit 19 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select: 0 read pointer, 1 write pointer, 2 count, 3 control |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr |
| req_lines | input | NREQ | Transfer-request lines used for pacing |
| rd_valid | output | 1 | Read request valid |
| rd_ready | input | 1 | Read request accepted |
| rd_addr | output | AW | Read byte address |
| rd_size | output | 2 | Read width code |
| rd_resp_valid | input | 1 | Read response valid |
| rd_resp_err | input | 1 | Read response error |
| rd_resp_data | input | DW | Read data, right-justified |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Write request accepted |
| wr_addr | output | AW | Write byte address |
| wr_size | output | 2 | Write width code |
| wr_data | output | DW | Write data, right-justified |
| wr_resp_valid | input | 1 | Write response valid |
| wr_resp_err | input | 1 | Write response error |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| irq | output | 1 | Sticky completion interrupt request |

## Verification
The checks assume that each bus side returns exactly one response per accepted request, and only after it. The bench memory model always replies one cycle after the handshake, so a response never arrives uninvited. They also assume the control word is not rewritten while a sequence runs, because the monotonic-count and pacing checks follow the stored fields. The bench changes only the pointer and count registers during a paced, stalled sequence.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

   localparam int RING_W = 4;
   localparam int SEL_W  = 3;

   typedef enum logic [1:0] {
      REG_RPTR  = 2'd0,
      REG_WPTR  = 2'd1,
      REG_COUNT = 2'd2,
      REG_CTRL  = 2'd3
   } reg_sel_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD_REQ,
      ST_RD_WAIT,
      ST_WR_REQ,
      ST_WR_WAIT
   } seq_state_e;

   // control word bit positions
   localparam int CB_SIZE  = 0;
   localparam int CB_RINC  = 2;
   localparam int CB_WINC  = 3;
   localparam int CB_RING  = 4;
   localparam int CB_RSEL  = 8;
   localparam int CB_SWAP  = 9;
   localparam int CB_PACE  = 10;
   localparam int CB_REQ   = 11;
   localparam int CB_QUIET = 14;
   localparam int CB_RERR  = 16;
   localparam int CB_WERR  = 17;
   localparam int CB_ERR   = 18;
   localparam int CB_IRQ   = 19;
   localparam int CB_BUSY  = 24;
   localparam int CB_START = 31;

   typedef struct packed {
      logic              quiet;
      logic [SEL_W-1:0]  req_sel;
      logic              pace;
      logic              swap;
      logic              ring_wr;
      logic [RING_W-1:0] ring;
      logic              winc;
      logic              rinc;
      logic [1:0]        size;
   } ctrl_t;

   function automatic ctrl_t ctrl_from_word(input logic [31:0] w);
      ctrl_t c;
      c.size    = w[CB_SIZE +: 2];
      c.rinc    = w[CB_RINC];
      c.winc    = w[CB_WINC];
      c.ring    = w[CB_RING +: RING_W];
      c.ring_wr = w[CB_RSEL];
      c.swap    = w[CB_SWAP];
      c.pace    = w[CB_PACE];
      c.req_sel = w[CB_REQ +: SEL_W];
      c.quiet   = w[CB_QUIET];
      return c;
   endfunction

   function automatic logic [31:0] ctrl_to_word(input ctrl_t c);
      logic [31:0] w;
      w = '0;
      w[CB_SIZE +: 2]      = c.size;
      w[CB_RINC]           = c.rinc;
      w[CB_WINC]           = c.winc;
      w[CB_RING +: RING_W] = c.ring;
      w[CB_RSEL]           = c.ring_wr;
      w[CB_SWAP]           = c.swap;
      w[CB_PACE]           = c.pace;
      w[CB_REQ +: SEL_W]   = c.req_sel;
      w[CB_QUIET]          = c.quiet;
      return w;
   endfunction

endpackage

// File: rtl/dma_seq_addr_step.sv
module dma_seq_addr_step #(
   parameter int AW     = 32,
   parameter int RING_W = 4
) (
   input  logic [AW-1:0]     addr_i,
   input  logic [1:0]        size_i,
   input  logic              inc_i,
   input  logic [RING_W-1:0] ring_i,
   input  logic              wrap_i,
   output logic [AW-1:0]     next_o
);
   localparam int MAX_RING = (1 << RING_W) - 1;

   if (AW <= MAX_RING) begin : g_bad_aw
      $error("dma_seq_addr_step: AW must exceed the largest ring size");
   end

   logic [AW-1:0] step;
   logic [AW-1:0] sum;
   logic [AW-1:0] keep_mask;

   always_comb begin
      if (!inc_i)             step = '0;
      else if (size_i == 2'd0) step = AW'(1);
      else if (size_i == 2'd1) step = AW'(2);
      else                    step = AW'(4);
   end

   assign sum = addr_i + step;

   always_comb begin
      if (!wrap_i || ring_i == '0) keep_mask = '1;
      else                         keep_mask = (AW'(1) << ring_i) - AW'(1);
   end

   assign next_o = (addr_i & ~keep_mask) | (sum & keep_mask);

endmodule

// File: rtl/dma_seq_swap.sv
module dma_seq_swap #(
   parameter int DW = 32
) (
   input  logic [DW-1:0] data_i,
   input  logic [1:0]    size_i,
   input  logic          en_i,
   output logic [DW-1:0] data_o
);
   localparam int NB = DW / 8;

   if (DW != 32) begin : g_bad_dw
      $error("dma_seq_swap: only a 32-bit data path is supported");
   end

   logic [DW-1:0] rev_word;
   logic [DW-1:0] rev_half;

   for (genvar b = 0; b < NB; b++) begin : g_rev
      assign rev_word[8*b +: 8] = data_i[8*(NB-1-b) +: 8];
   end

   assign rev_half = {data_i[DW-1:16], data_i[7:0], data_i[15:8]};

   always_comb begin
      if (!en_i || size_i == 2'd0) data_o = data_i;
      else if (size_i == 2'd1)     data_o = rev_half;
      else                         data_o = rev_word;
   end

endmodule

// File: rtl/dma_seq_pacer.sv
module dma_seq_pacer #(
   parameter int NREQ  = 8,
   parameter int SEL_W = 3
) (
   input  logic [NREQ-1:0]  req_i,
   input  logic [SEL_W-1:0] sel_i,
   input  logic             en_i,
   output logic             go_o
);
   localparam int SLOTS = 1 << SEL_W;

   if (NREQ < 1 || NREQ > SLOTS) begin : g_bad_nreq
      $error("dma_seq_pacer: NREQ out of range for the select field");
   end

   if (NREQ == 1) begin : g_single
      logic unused_sel;
      assign unused_sel = ^sel_i;
      assign go_o = !en_i || req_i[0];
   end else begin : g_multi
      logic [SLOTS-1:0] padded;
      always_comb begin
         padded = '0;
         padded[NREQ-1:0] = req_i;
      end
      assign go_o = !en_i || padded[sel_i];
   end

endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
   import dma_seq_pkg::*;
#(
   parameter int AW    = 32,
   parameter int DW    = 32,
   parameter int CNT_W = 16,
   parameter int NREQ  = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cfg_we,
   input  logic [1:0]      cfg_addr,
   input  logic [31:0]     cfg_wdata,
   output logic [31:0]     cfg_rdata,
   input  logic [NREQ-1:0] req_lines,
   output logic            rd_valid,
   input  logic            rd_ready,
   output logic [AW-1:0]   rd_addr,
   output logic [1:0]      rd_size,
   input  logic            rd_resp_valid,
   input  logic            rd_resp_err,
   input  logic [DW-1:0]   rd_resp_data,
   output logic            wr_valid,
   input  logic            wr_ready,
   output logic [AW-1:0]   wr_addr,
   output logic [1:0]      wr_size,
   output logic [DW-1:0]   wr_data,
   input  logic            wr_resp_valid,
   input  logic            wr_resp_err,
   output logic            busy,
   output logic            done,
   output logic            irq
);

   if (AW > 32 || AW < 16) begin : g_bad_aw
      $error("dma_chan_seq: AW must be within 16..32");
   end
   if (CNT_W > 32 || CNT_W < 1) begin : g_bad_cnt
      $error("dma_chan_seq: CNT_W must be within 1..32");
   end

   seq_state_e     state;
   ctrl_t          ctrl_q;
   logic [AW-1:0]  rd_ptr, wr_ptr, rd_next, wr_next;
   logic [CNT_W-1:0] reload, remaining;
   logic [DW-1:0]  data_q, swapped;
   logic           rd_err_q, wr_err_q, irq_q, done_q;
   logic           pace_go;

   // register decode
   logic wr_rptr, wr_wptr, wr_count, wr_ctrl, start_cmd;
   assign wr_rptr   = cfg_we && (cfg_addr == REG_RPTR);
   assign wr_wptr   = cfg_we && (cfg_addr == REG_WPTR);
   assign wr_count  = cfg_we && (cfg_addr == REG_COUNT);
   assign wr_ctrl   = cfg_we && (cfg_addr == REG_CTRL);
   assign start_cmd = wr_ctrl && cfg_wdata[CB_START] && (state == ST_IDLE);

   logic unused_wdata;
   assign unused_wdata = ^{cfg_wdata[30:20], cfg_wdata[15]};

   // sequence events
   logic finish, rd_fail, wr_fail, step_ok;
   assign finish  = (state == ST_RD_REQ) && (remaining == '0);
   assign rd_fail = (state == ST_RD_WAIT) && rd_resp_valid && rd_resp_err;
   assign wr_fail = (state == ST_WR_WAIT) && wr_resp_valid && wr_resp_err;
   assign step_ok = (state == ST_WR_WAIT) && wr_resp_valid && !wr_resp_err;

   dma_seq_addr_step #(.AW(AW), .RING_W(RING_W)) u_rd_step (
      .addr_i (rd_ptr),
      .size_i (ctrl_q.size),
      .inc_i  (ctrl_q.rinc),
      .ring_i (ctrl_q.ring),
      .wrap_i (!ctrl_q.ring_wr),
      .next_o (rd_next)
   );

   dma_seq_addr_step #(.AW(AW), .RING_W(RING_W)) u_wr_step (
      .addr_i (wr_ptr),
      .size_i (ctrl_q.size),
      .inc_i  (ctrl_q.winc),
      .ring_i (ctrl_q.ring),
      .wrap_i (ctrl_q.ring_wr),
      .next_o (wr_next)
   );

   dma_seq_swap #(.DW(DW)) u_swap (
      .data_i (rd_resp_data),
      .size_i (ctrl_q.size),
      .en_i   (ctrl_q.swap),
      .data_o (swapped)
   );

   dma_seq_pacer #(.NREQ(NREQ), .SEL_W(SEL_W)) u_pacer (
      .req_i (req_lines),
      .sel_i (ctrl_q.req_sel),
      .en_i  (ctrl_q.pace),
      .go_o  (pace_go)
   );

   // sequencer
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         remaining <= '0;
         data_q    <= '0;
         done_q    <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (start_cmd) begin
                  remaining <= reload;
                  state     <= ST_RD_REQ;
               end
            end
            ST_RD_REQ: begin
               if (finish) begin
                  state  <= ST_IDLE;
                  done_q <= 1'b1;
               end else if (rd_valid && rd_ready) begin
                  state <= ST_RD_WAIT;
               end
            end
            ST_RD_WAIT: begin
               if (rd_resp_valid) begin
                  if (rd_resp_err) begin
                     state <= ST_IDLE;
                  end else begin
                     data_q <= swapped;
                     state  <= ST_WR_REQ;
                  end
               end
            end
            ST_WR_REQ: begin
               if (wr_ready) state <= ST_WR_WAIT;
            end
            ST_WR_WAIT: begin
               if (wr_resp_valid) begin
                  if (wr_resp_err) begin
                     state <= ST_IDLE;
                  end else begin
                     remaining <= remaining - 1'b1;
                     state     <= ST_RD_REQ;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // pointers: a register write wins over the sequencer step
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
      end else begin
         if (wr_rptr)      rd_ptr <= cfg_wdata[AW-1:0];
         else if (step_ok) rd_ptr <= rd_next;
         if (wr_wptr)      wr_ptr <= cfg_wdata[AW-1:0];
         else if (step_ok) wr_ptr <= wr_next;
      end
   end

   // configuration and sticky flags
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q   <= '0;
         reload   <= '0;
         rd_err_q <= 1'b0;
         wr_err_q <= 1'b0;
         irq_q    <= 1'b0;
      end else begin
         if (wr_count) reload <= cfg_wdata[CNT_W-1:0];
         if (wr_ctrl)  ctrl_q <= ctrl_from_word(cfg_wdata);

         if (rd_fail)                           rd_err_q <= 1'b1;
         else if (wr_ctrl && cfg_wdata[CB_RERR]) rd_err_q <= 1'b0;

         if (wr_fail)                           wr_err_q <= 1'b1;
         else if (wr_ctrl && cfg_wdata[CB_WERR]) wr_err_q <= 1'b0;

         if (finish && !ctrl_q.quiet)           irq_q <= 1'b1;
         else if (wr_ctrl && cfg_wdata[CB_IRQ])  irq_q <= 1'b0;
      end
   end

   // outputs
   assign busy     = (state != ST_IDLE);
   assign done     = done_q;
   assign irq      = irq_q;
   assign rd_valid = (state == ST_RD_REQ) && (remaining != '0) && pace_go;
   assign rd_addr  = rd_ptr;
   assign rd_size  = ctrl_q.size;
   assign wr_valid = (state == ST_WR_REQ);
   assign wr_addr  = wr_ptr;
   assign wr_size  = ctrl_q.size;
   assign wr_data  = data_q;

   always_comb begin
      cfg_rdata = '0;
      case (cfg_addr)
         REG_RPTR:  cfg_rdata[AW-1:0]    = rd_ptr;
         REG_WPTR:  cfg_rdata[AW-1:0]    = wr_ptr;
         REG_COUNT: cfg_rdata[CNT_W-1:0] = remaining;
         default: begin
            cfg_rdata           = ctrl_to_word(ctrl_q);
            cfg_rdata[CB_RERR]  = rd_err_q;
            cfg_rdata[CB_WERR]  = wr_err_q;
            cfg_rdata[CB_ERR]   = rd_err_q | wr_err_q;
            cfg_rdata[CB_IRQ]   = irq_q;
            cfg_rdata[CB_BUSY]  = busy;
         end
      endcase
   end

   // checks on the sequencer
   assert_pace_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && ctrl_q.pace) |-> pace_go);

   assert_issue_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid || wr_valid) |-> busy);

   assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_count_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> (remaining <= $past(remaining)));

   assert_err_stops_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_fail || wr_fail) |=> (!busy && !done));

endmodule

// File: tb/dma_chan_seq_test.sv
module dma_chan_seq_test;
   localparam int CLK_PERIOD = 10;
   localparam int NREQ = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_addr = 2'd0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic [NREQ-1:0] req_lines = '0;
   logic        rd_valid, wr_valid;
   logic        rd_ready = 1'b1, wr_ready = 1'b1;
   logic [31:0] rd_addr, wr_addr, wr_data;
   logic [1:0]  rd_size, wr_size;
   logic        rd_resp_valid = 1'b0, rd_resp_err = 1'b0;
   logic [31:0] rd_resp_data = '0;
   logic        wr_resp_valid = 1'b0, wr_resp_err = 1'b0;
   logic        busy, done, irq;

   always #(CLK_PERIOD/2) clk = ~clk;

   dma_chan_seq uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_lines(req_lines),
      .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr), .rd_size(rd_size),
      .rd_resp_valid(rd_resp_valid), .rd_resp_err(rd_resp_err), .rd_resp_data(rd_resp_data),
      .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_size(wr_size),
      .wr_data(wr_data), .wr_resp_valid(wr_resp_valid), .wr_resp_err(wr_resp_err),
      .busy(busy), .done(done), .irq(irq)
   );

   // bus memory model
   logic [7:0] mem    [256];
   logic [7:0] shadow [256];
   logic       err_rd_en = 1'b0, err_wr_en = 1'b0;
   logic [7:0] err_at = 8'h00;
   int n_rd = 0, n_done = 0, cyc = 0;
   int checks = 0, errors = 0;

   function automatic logic [7:0] init_byte(input int i);
      return 8'((i * 7 + 3) & 255);
   endfunction

   function automatic logic [31:0] mem_read(input logic [7:0] a, input logic [1:0] sz);
      logic [31:0] v;
      v = '0;
      v[7:0] = mem[a];
      if (sz != 2'd0) v[15:8] = mem[8'(a + 1)];
      if (sz >= 2'd2) begin
         v[23:16] = mem[8'(a + 2)];
         v[31:24] = mem[8'(a + 3)];
      end
      return v;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 256; i++) mem[i] <= init_byte(i);
         rd_resp_valid <= 1'b0;
         wr_resp_valid <= 1'b0;
      end else begin
         rd_resp_valid <= 1'b0;
         rd_resp_err   <= 1'b0;
         wr_resp_valid <= 1'b0;
         wr_resp_err   <= 1'b0;
         if (rd_valid && rd_ready) begin
            n_rd <= n_rd + 1;
            rd_resp_valid <= 1'b1;
            rd_resp_err   <= err_rd_en && (rd_addr[7:0] == err_at);
            rd_resp_data  <= mem_read(rd_addr[7:0], rd_size);
         end
         if (wr_valid && wr_ready) begin
            wr_resp_valid <= 1'b1;
            if (err_wr_en && (wr_addr[7:0] == err_at)) begin
               wr_resp_err <= 1'b1;
            end else begin
               mem[wr_addr[7:0]] <= wr_data[7:0];
               if (wr_size != 2'd0) mem[8'(wr_addr[7:0] + 1)] <= wr_data[15:8];
               if (wr_size >= 2'd2) begin
                  mem[8'(wr_addr[7:0] + 2)] <= wr_data[23:16];
                  mem[8'(wr_addr[7:0] + 3)] <= wr_data[31:24];
               end
            end
         end
      end
   end

   always @(posedge clk) begin
      if (done) n_done <= n_done + 1;
   end

   // watchdog
   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == 150000) begin
         checks = checks + 1;
         errors = errors + 1;
         $display("FAIL R2 watchdog act=running exp=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks = checks + 1;
      if (act !== exp) begin
         errors = errors + 1;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic wreg(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic rreg(input logic [1:0] a, output logic [31:0] d);
      @(negedge clk);
      cfg_addr = a;
      #1 d = cfg_rdata;
   endtask

   task automatic wait_idle();
      int n = 0;
      while (busy && n < 5000) begin
         @(negedge clk);
         n++;
      end
      repeat (3) @(negedge clk);
   endtask

   function automatic logic [31:0] mk(input int sz, input bit ri, input bit wi, input int ring,
                                      input bit rw, input bit sw, input bit pace, input int sel,
                                      input bit quiet, input bit start);
      logic [31:0] w;
      w = '0;
      w[1:0] = 2'(sz); w[2] = ri; w[3] = wi; w[7:4] = 4'(ring); w[8] = rw;
      w[9] = sw; w[10] = pace; w[13:11] = 3'(sel); w[14] = quiet; w[31] = start;
      return w;
   endfunction

   function automatic int adv(input int a, input int step, input int ring, input bit wrap);
      int m;
      if (!wrap || ring == 0) return a + step;
      m = (1 << ring) - 1;
      return (a & ~m) | ((a + step) & m);
   endfunction

   task automatic model(input int sz, input bit ri, input bit wi, input int ring, input bit rw,
                        input bit sw, input int ra, input int wa, input int cnt);
      logic [7:0] tmp [4];
      int n;
      n = 1 << sz;
      for (int t = 0; t < cnt; t++) begin
         for (int i = 0; i < n; i++) tmp[i] = shadow[(ra + i) & 255];
         for (int i = 0; i < n; i++) shadow[(wa + i) & 255] = sw ? tmp[n-1-i] : tmp[i];
         ra = adv(ra, ri ? n : 0, ring, !rw);
         wa = adv(wa, wi ? n : 0, ring, rw);
      end
   endtask

   task automatic cmp_mem(input string req);
      int bad = 0;
      for (int i = 0; i < 256; i++) if (mem[i] !== shadow[i]) bad++;
      chk(req, 32'(bad), 32'd0);
   endtask

   typedef struct packed {
      logic [1:0] sz; logic ri; logic wi; logic [3:0] ring; logic rw; logic sw;
      logic [7:0] ra; logic [7:0] wa; logic [3:0] cnt; logic [7:0] era; logic [7:0] ewa;
   } vec_t;

   localparam vec_t TABLE [6] = '{
      '{2'd2, 1'b1, 1'b1, 4'd0, 1'b0, 1'b0, 8'h00, 8'h80, 4'd4, 8'h10, 8'h90},
      '{2'd1, 1'b1, 1'b1, 4'd0, 1'b0, 1'b1, 8'h20, 8'hA0, 4'd3, 8'h26, 8'hA6},
      '{2'd0, 1'b1, 1'b0, 4'd0, 1'b0, 1'b0, 8'h30, 8'hC0, 4'd5, 8'h35, 8'hC0},
      '{2'd2, 1'b1, 1'b1, 4'd3, 1'b0, 1'b0, 8'h40, 8'hD0, 4'd4, 8'h40, 8'hE0},
      '{2'd2, 1'b1, 1'b1, 4'd4, 1'b1, 1'b1, 8'h50, 8'hF8, 4'd3, 8'h5C, 8'hF4},
      '{2'd1, 1'b0, 1'b1, 4'd0, 1'b0, 1'b0, 8'h60, 8'h70, 4'd2, 8'h60, 8'h74}
   };

   function automatic string tag_of(input int e);
      case (e)
         1: return "R5 halfword swap";
         2: return "R3 fixed write pointer";
         3: return "R4 read ring";
         4: return "R4 write ring with swap";
         5: return "R3 fixed read pointer";
         default: return "R1 word copy";
      endcase
   endfunction

   initial begin
      logic [31:0] d;
      int rd0, dn0;
      for (int i = 0; i < 256; i++) shadow[i] = init_byte(i);
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state
      rreg(2'd0, d); chk("R10 reset read pointer", d, 32'h0);
      rreg(2'd1, d); chk("R10 reset write pointer", d, 32'h0);
      rreg(2'd2, d); chk("R9 reset count", d, 32'h0);
      rreg(2'd3, d); chk("R7 reset control", d, 32'h0);
      chk("R7 reset busy", 32'(busy), 32'd0);
      chk("R11 reset done", 32'(done), 32'd0);
      chk("R11 reset irq", 32'(irq), 32'd0);

      // table-driven transfers
      for (int e = 0; e < 6; e++) begin
         vec_t v;
         v = TABLE[e];
         wreg(2'd0, 32'(v.ra));
         wreg(2'd1, 32'(v.wa));
         wreg(2'd2, 32'(v.cnt));
         rd0 = n_rd; dn0 = n_done;
         wreg(2'd3, mk(v.sz, v.ri, v.wi, v.ring, v.rw, v.sw, 0, 0, 0, 1));
         wait_idle();
         model(v.sz, v.ri, v.wi, v.ring, v.rw, v.sw, v.ra, v.wa, v.cnt);
         rreg(2'd0, d); chk({tag_of(e), " final read pointer"}, d, 32'(v.era));
         rreg(2'd1, d); chk({tag_of(e), " final write pointer"}, d, 32'(v.ewa));
         cmp_mem({tag_of(e), " memory mismatches"});
         chk("R2 reads issued", 32'(n_rd - rd0), 32'(v.cnt));
         chk("R11 done pulse cycles", 32'(n_done - dn0), 32'd1);
         if (e == 0) chk("R11 irq after loud run", 32'(irq), 32'd1);
         wreg(2'd3, 32'h0008_0000);
      end
      chk("R11 irq cleared by W1C", 32'(irq), 32'd0);

      // zero count
      wreg(2'd2, 32'd0);
      rd0 = n_rd; dn0 = n_done;
      wreg(2'd3, mk(2, 1, 1, 0, 0, 0, 0, 0, 1, 1));
      wait_idle();
      chk("R2 zero count issues no read", 32'(n_rd - rd0), 32'd0);
      chk("R2 zero count still completes", 32'(n_done - dn0), 32'd1);
      chk("R11 quiet run leaves irq low", 32'(irq), 32'd0);

      // pacing, live count and immediate pointer writes
      req_lines = 8'hDF;
      wreg(2'd0, 32'h0000_0000);
      wreg(2'd1, 32'h0000_00B0);
      wreg(2'd2, 32'd3);
      rd0 = n_rd;
      wreg(2'd3, mk(2, 1, 1, 0, 0, 0, 1, 5, 0, 1));
      repeat (20) @(negedge clk);
      chk("R6 no read while line low", 32'(n_rd - rd0), 32'd0);
      chk("R7 busy port while running", 32'(busy), 32'd1);
      rreg(2'd3, d); chk("R7 busy bit while running", 32'(d[24]), 32'd1);
      rreg(2'd2, d); chk("R9 remaining while stalled", d, 32'd3);
      wreg(2'd2, 32'd7);
      rreg(2'd2, d); chk("R9 reload write leaves remaining", d, 32'd3);
      wreg(2'd0, 32'h0000_0008);
      rreg(2'd0, d); chk("R10 pointer write visible", d, 32'h8);
      req_lines = 8'h20;
      wait_idle();
      model(2, 1, 1, 0, 0, 0, 8, 'hB0, 3);
      rreg(2'd0, d); chk("R10 run used new pointer", d, 32'h14);
      rreg(2'd1, d); chk("R1 write pointer advanced", d, 32'hBC);
      rreg(2'd2, d); chk("R9 remaining at end", d, 32'd0);
      chk("R7 busy low after end", 32'(busy), 32'd0);
      chk("R6 reads once released", 32'(n_rd - rd0), 32'd3);
      cmp_mem("R6 paced copy memory mismatches");
      req_lines = '0;
      wreg(2'd3, 32'h0008_0000);

      // read error
      err_rd_en = 1'b1; err_at = 8'h44;
      wreg(2'd0, 32'h40); wreg(2'd1, 32'h60); wreg(2'd2, 32'd4);
      dn0 = n_done;
      wreg(2'd3, mk(2, 1, 1, 0, 0, 0, 0, 0, 0, 1));
      wait_idle();
      err_rd_en = 1'b0;
      model(2, 1, 1, 0, 0, 0, 'h40, 'h60, 1);
      rreg(2'd3, d);
      chk("R8 read error flag", 32'(d[16]), 32'd1);
      chk("R8 write flag clear", 32'(d[17]), 32'd0);
      chk("R8 combined flag", 32'(d[18]), 32'd1);
      chk("R8 no done on abort", 32'(n_done - dn0), 32'd0);
      rreg(2'd0, d); chk("R8 read pointer held at failed read", d, 32'h44);
      wreg(2'd3, 32'h0001_0000);
      rreg(2'd3, d); chk("R8 W1C clears combined flag", {d[18], d[16]}, 32'd0);

      // write error
      err_wr_en = 1'b1; err_at = 8'h64;
      wreg(2'd0, 32'h00); wreg(2'd1, 32'h64); wreg(2'd2, 32'd2);
      wreg(2'd3, mk(2, 1, 1, 0, 0, 0, 0, 0, 0, 1));
      wait_idle();
      err_wr_en = 1'b0;
      rreg(2'd3, d);
      chk("R8 write error flag", {d[18], d[17], d[16]}, 32'b110);
      rreg(2'd0, d); chk("R8 pointer not advanced on write error", d, 32'h0);
      wreg(2'd3, 32'h0002_0000);
      rreg(2'd3, d); chk("R8 write flag cleared", {d[18], d[17]}, 32'd0);
      cmp_mem("R8 memory after aborts");
      chk("R11 irq stays low on abort", 32'(irq), 32'd0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule